// File: doc/BRIEF.md
# System Interrupt Router with Level Mapping

This block is the system-level interrupt router of a multiprocessor chip. It watches 32 device interrupt lines and records, per line, whether a request is outstanding. A mask word decides which sources may reach a processor. Each line carries a fixed priority level from a build-time table, and every enabled outstanding source raises its level in a 16-entry level request vector.

That vector goes to exactly one processor, chosen by software, out of up to 16. All other processors see no system request. Software reaches the block through a small word-addressed register window. Through it, software reads the outstanding and mask words, enables or disables sources with write-one-to-act words, and picks the target processor. Disabling a source also throws away its outstanding request. A group of mask bits is hard-wired to stay enabled. The top mask bit acts as a master gate for all delivery.

Top module: `sysirq_router`

## Requirements
- R1: After reset, the pending word is 0, the target is processor 0, the mask word is 32'h004DFF80, and every request output is 0.
- R2: The read data is decided by the word offset `busAddr`. Offset 0 returns the pending word with bit 31 forced to 0. Offset 1 returns the mask word. Offset 4 returns the target number, zero-extended. Offsets 2, 3, 5, 6 and 7 return 0. The read data follows the address in the same cycle.
- R3: A write to offset 2 clears every mask bit that is 1 in the write data, which enables those sources.
- R4: A write to offset 3 sets every mask bit that is 1 in the write data and clears the same pending bits. If a source has a rising edge in the same cycle, the discard wins and the pending bit stays 0.
- R5: Before a write to offset 2 or 3 takes effect, the data bits under 32'h4FB2007F are forced to 0, so those mask bits never change.
- R6: A write to offset 4 stores the low log2(NUM_CPU) data bits as the target number.
- R7: A 0-to-1 change on an input whose table level is nonzero sets its pending bit, whatever the mask. A 1-to-0 change clears it. An input whose level is 0 never sets a pending bit.
- R8: While mask bit 31 is 1, every request output is 0.
- R9: While mask bit 31 is 0, the target's 16-bit request vector has bit L set exactly when some source of level L is pending and not masked. The outputs are registered, and they reflect the state one clock after that state is stored.
- R10: Processors other than the target receive an all-zero request vector.
- R11: Writes to offsets 0, 1, 5, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | Device interrupt lines |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Word offset within the register window (byte address bits 4:2) |
| busWrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the addressed word |
| cpuLvlReq | output | NUM_CPU*16 | Level request vectors, 16 bits per processor, processor 0 in the lowest slice |

## Verification
A disable write and a rising edge on the same source can land on the same clock edge. The first would discard the pending bit and the second would set it. The bench provokes this by driving the input and the offset-3 write on the same falling edge. It then judges the result by reading offset 0 and by checking that the request outputs stay at zero, since the discard must win. A second overlap, a target change while a source stays pending, is judged by checking that the request vector moves to the new processor and leaves the old one clear.

// File: rtl/sysirq_pkg.sv
package sysirq_pkg;

  localparam int SRC_N  = 32;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_PEND = 3'd0,
    OFS_MASK = 3'd1,
    OFS_ENA  = 3'd2,
    OFS_DIS  = 3'd3,
    OFS_TGT  = 3'd4
  } regOfs_e;

  // strobes from the decoder to the state datapath
  typedef struct packed {
    logic              enaStb;
    logic              disStb;
    logic              tgtStb;
    logic [WORD_W-1:0] maskBits;   // write data with hard-wired bits removed
  } ctlStb_t;

endpackage

// File: rtl/sysirq_ctrl.sv
module sysirq_ctrl
  import sysirq_pkg::*;
#(
  parameter int              CPU_W      = 4,
  parameter logic [WORD_W-1:0] FIXED_MASK = 32'h4FB2007F
) (
  input  logic              busWr,
  input  logic [OFS_W-1:0]  busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output ctlStb_t           stb,
  output logic [CPU_W-1:0]  tgtVal
);

  regOfs_e ofs;

  always_comb begin
    ofs          = regOfs_e'(busAddr);
    stb.enaStb   = 1'b0;
    stb.disStb   = 1'b0;
    stb.tgtStb   = 1'b0;
    stb.maskBits = busWrData & ~FIXED_MASK;
    if (busWr) begin
      case (ofs)
        OFS_ENA: stb.enaStb = 1'b1;
        OFS_DIS: stb.disStb = 1'b1;
        OFS_TGT: stb.tgtStb = 1'b1;
        default: ;
      endcase
    end
  end

  assign tgtVal = busWrData[CPU_W-1:0];

endmodule

// File: rtl/sysirq_state.sv
module sysirq_state
  import sysirq_pkg::*;
#(
  parameter int                      CPU_W       = 4,
  parameter int                      LVL_W       = 4,
  parameter logic [SRC_N*LVL_W-1:0]  LEVEL_TABLE = '0,
  parameter logic [WORD_W-1:0]       DIS_RESET   = 32'h004DFF80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  irqIn,
  input  ctlStb_t           stb,
  input  logic [CPU_W-1:0]  tgtVal,
  input  logic [OFS_W-1:0]  rdOfs,
  output logic [SRC_N-1:0]  pendReg,
  output logic [WORD_W-1:0] disReg,
  output logic [CPU_W-1:0]  tgtReg,
  output logic [WORD_W-1:0] rdData
);

  logic [SRC_N-1:0] liveMask;
  logic [SRC_N-1:0] irqPrev;
  logic [SRC_N-1:0] riseV, fallV, pendNext;
  logic [WORD_W-1:0] disNext;

  // sources mapped to level 0 never record anything
  for (genvar i = 0; i < SRC_N; i++) begin : g_live
    assign liveMask[i] = |LEVEL_TABLE[i*LVL_W +: LVL_W];
  end

  assign riseV = irqIn & ~irqPrev & liveMask;
  assign fallV = ~irqIn & irqPrev & liveMask;

  always_comb begin
    pendNext = (pendReg | riseV) & ~fallV;
    disNext  = disReg;
    if (stb.enaStb) disNext = disReg & ~stb.maskBits;
    if (stb.disStb) begin
      disNext  = disReg | stb.maskBits;
      pendNext = pendNext & ~stb.maskBits;   // discard beats a same-cycle edge
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqPrev <= '0;
      pendReg <= '0;
      disReg  <= DIS_RESET;
      tgtReg  <= '0;
    end else begin
      irqPrev <= irqIn;
      pendReg <= pendNext;
      disReg  <= disNext;
      if (stb.tgtStb) tgtReg <= tgtVal;
    end
  end

  always_comb begin
    case (regOfs_e'(rdOfs))
      OFS_PEND: rdData = {1'b0, pendReg[SRC_N-2:0]};
      OFS_MASK: rdData = disReg;
      OFS_TGT:  rdData = WORD_W'(tgtReg);
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/sysirq_route.sv
module sysirq_route
  import sysirq_pkg::*;
#(
  parameter int                     NUM_CPU     = 16,
  parameter int                     CPU_W       = 4,
  parameter int                     LVL_W       = 4,
  parameter logic [SRC_N*LVL_W-1:0] LEVEL_TABLE = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SRC_N-1:0]              pendReg,
  input  logic [WORD_W-1:0]             disReg,
  input  logic [CPU_W-1:0]              tgtReg,
  output logic [NUM_CPU*(1<<LVL_W)-1:0] cpuLvlReq
);

  localparam int NUM_LVL = 1 << LVL_W;

  logic [SRC_N-1:0]   effV;
  logic [NUM_LVL-1:0] lvlVec;

  assign effV = pendReg & ~disReg[SRC_N-1:0];

  always_comb begin
    lvlVec = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (effV[i]) lvlVec[LEVEL_TABLE[i*LVL_W +: LVL_W]] = 1'b1;
    end
    if (disReg[WORD_W-1]) lvlVec = '0;   // master gate
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rst_n) cpuLvlReq[c*NUM_LVL +: NUM_LVL] <= '0;
      else        cpuLvlReq[c*NUM_LVL +: NUM_LVL] <= (tgtReg == CPU_W'(c)) ? lvlVec : '0;
    end
  end

endmodule

// File: rtl/sysirq_router.sv
module sysirq_router
  import sysirq_pkg::*;
#(
  parameter int                     NUM_CPU     = 16,
  parameter int                     LVL_W       = 4,
  parameter logic [SRC_N*LVL_W-1:0] LEVEL_TABLE = 128'hFEDCBA98765432_10_FEDCBA9876543210,
  parameter logic [WORD_W-1:0]      FIXED_MASK  = 32'h4FB2007F,
  parameter logic [WORD_W-1:0]      DIS_RESET   = 32'h004DFF80
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SRC_N-1:0]              irqIn,
  input  logic                          busWr,
  input  logic [OFS_W-1:0]              busAddr,
  input  logic [WORD_W-1:0]             busWrData,
  output logic [WORD_W-1:0]             rdData,
  output logic [NUM_CPU*(1<<LVL_W)-1:0] cpuLvlReq
);

  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  ctlStb_t           stb;
  logic [CPU_W-1:0]  tgtVal;
  logic [SRC_N-1:0]  pendReg;
  logic [WORD_W-1:0] disReg;
  logic [CPU_W-1:0]  tgtReg;

  sysirq_ctrl #(.CPU_W(CPU_W), .FIXED_MASK(FIXED_MASK)) ctrl_i (
    .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
    .stb(stb), .tgtVal(tgtVal)
  );

  sysirq_state #(.CPU_W(CPU_W), .LVL_W(LVL_W), .LEVEL_TABLE(LEVEL_TABLE),
                 .DIS_RESET(DIS_RESET)) state_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .stb(stb), .tgtVal(tgtVal),
    .rdOfs(busAddr), .pendReg(pendReg), .disReg(disReg), .tgtReg(tgtReg),
    .rdData(rdData)
  );

  sysirq_route #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .LVL_W(LVL_W),
                 .LEVEL_TABLE(LEVEL_TABLE)) route_i (
    .clk(clk), .rst_n(rst_n), .pendReg(pendReg), .disReg(disReg),
    .tgtReg(tgtReg), .cpuLvlReq(cpuLvlReq)
  );

endmodule

// File: rtl/sysirq_router_chk.sv
module sysirq_router_chk
  import sysirq_pkg::*;
#(
  parameter int                     NUM_CPU     = 16,
  parameter int                     CPU_W       = 4,
  parameter int                     LVL_W       = 4,
  parameter logic [SRC_N*LVL_W-1:0] LEVEL_TABLE = '0,
  parameter logic [WORD_W-1:0]      FIXED_MASK  = 32'h4FB2007F
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          busWr,
  input logic [OFS_W-1:0]              busAddr,
  input logic [WORD_W-1:0]             busWrData,
  input logic [SRC_N-1:0]              pendReg,
  input logic [WORD_W-1:0]             disReg,
  input logic [CPU_W-1:0]              tgtReg,
  input logic [NUM_CPU*(1<<LVL_W)-1:0] cpuLvlReq
);

  localparam int NUM_LVL = 1 << LVL_W;

  function automatic logic [SRC_N-1:0] deadSrc();
    logic [SRC_N-1:0] m;
    for (int i = 0; i < SRC_N; i++) m[i] = (LEVEL_TABLE[i*LVL_W +: LVL_W] == '0);
    return m;
  endfunction
  localparam logic [SRC_N-1:0] DEAD_MASK = deadSrc();

  logic [NUM_CPU-1:0] cpuAny;
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_any
    assign cpuAny[c] = |cpuLvlReq[c*NUM_LVL +: NUM_LVL];
  end

  a_r4_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == 3'd3) |=> ((pendReg & $past(busWrData & ~FIXED_MASK)) == '0));

  a_r5_fixed_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (disReg & FIXED_MASK) == '0);

  a_r6_target_store: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == 3'd4) |=> (tgtReg == $past(busWrData[CPU_W-1:0])));

  a_r7_dead_source: assert property (@(posedge clk) disable iff (!rst_n)
    (pendReg & DEAD_MASK) == '0);

  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    disReg[WORD_W-1] |=> (cpuLvlReq == '0));

  a_r10_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuAny != '0) |-> (cpuAny == (NUM_CPU'(1) << $past(tgtReg))));

endmodule

bind sysirq_router sysirq_router_chk #(
  .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .LVL_W(LVL_W),
  .LEVEL_TABLE(LEVEL_TABLE), .FIXED_MASK(FIXED_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busWr(busWr), .busAddr(busAddr),
  .busWrData(busWrData), .pendReg(pendReg), .disReg(disReg),
  .tgtReg(tgtReg), .cpuLvlReq(cpuLvlReq)
);

// File: tb/sysirq_router_tb.sv
`timescale 1ns/1ps
module sysirq_router_tb_top;

  localparam int NCPU = 16;
  localparam int NL   = 16;
  localparam logic [31:0] FIX = 32'h4FB2007F;

  // bench table: source i has level i mod 16 (sources 0 and 16 are dead)
  function automatic logic [127:0] mkTable();
    logic [127:0] t;
    for (int i = 0; i < 32; i++) t[i*4 +: 4] = 4'(i % 16);
    return t;
  endfunction
  localparam logic [127:0] TBL = mkTable();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] irqIn = '0;
  logic busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] rdData;
  logic [NCPU*NL-1:0] cpuLvlReq;

  sysirq_router #(.NUM_CPU(NCPU), .LVL_W(4), .LEVEL_TABLE(TBL)) dut_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .rdData(rdData), .cpuLvlReq(cpuLvlReq)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mPend, mDis;
  logic [3:0]  mTgt;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit live(input int i);
    return (i % 16) != 0;
  endfunction

  task automatic setIn(input logic [31:0] v);
    for (int i = 0; i < 32; i++) begin
      if (live(i) && v[i] && !irqIn[i]) mPend[i] = 1'b1;
      if (live(i) && !v[i] && irqIn[i]) mPend[i] = 1'b0;
    end
    irqIn = v;
    tick(1);
  endtask

  task automatic mdlWrite(input int ofs, input logic [31:0] d);
    logic [31:0] m;
    m = d & ~FIX;
    if (ofs == 2) mDis = mDis & ~m;
    if (ofs == 3) begin mDis = mDis | m; mPend = mPend & ~m; end
    if (ofs == 4) mTgt = d[3:0];
  endtask

  task automatic busWrite(input int ofs, input logic [31:0] d);
    busWr = 1'b1; busAddr = 3'(ofs); busWrData = d;
    mdlWrite(ofs, d);
    tick(1);
    busWr = 1'b0;
  endtask

  function automatic logic [NCPU*NL-1:0] expOut();
    logic [NL-1:0] v;
    logic [NCPU*NL-1:0] o;
    v = '0; o = '0;
    if (!mDis[31])
      for (int i = 0; i < 32; i++) if (mPend[i] && !mDis[i]) v[i % 16] = 1'b1;
    o[mTgt*NL +: NL] = v;
    return o;
  endfunction

  task automatic chkOut(input string req);
    logic [NCPU*NL-1:0] e;
    e = expOut();
    checks++;
    if (cpuLvlReq !== e) begin
      errors++;
      $display("FAIL %s outputs actual=%h expected=%h", req, cpuLvlReq, e);
    end
  endtask

  task automatic chkRd(input int ofs, input logic [31:0] e, input string req);
    busAddr = 3'(ofs);
    #1;
    checks++;
    if (rdData !== e) begin
      errors++;
      $display("FAIL %s read ofs %0d actual=%h expected=%h", req, ofs, rdData, e);
    end
  endtask

  task automatic chkState(input string req);
    chkRd(0, {1'b0, mPend[30:0]}, req);
    chkRd(1, mDis, req);
    chkRd(4, {28'd0, mTgt}, req);
  endtask

  initial begin
    mPend = '0; mDis = 32'h004DFF80; mTgt = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset values
    chkState("R1");
    chkOut("R1");
    // R2 undefined offsets read zero
    for (int o = 2; o < 8; o++) if (o != 4) chkRd(o, 32'd0, "R2");

    // R3 enable everything writable
    busWrite(2, 32'hFFFF_FFFF);
    chkRd(1, 32'd0, "R3");

    // R7 R9 sweep: one source at a time
    for (int i = 0; i < 32; i++) begin
      setIn(32'd1 << i);
      tick(2);
      chkOut(live(i) ? "R9" : "R7");
      chkRd(0, {1'b0, mPend[30:0]}, "R2");
      setIn(32'd0);
      tick(2);
      chkOut("R7");
    end

    // R9 two sources on one level: dropping one keeps the level
    setIn(32'h0008_0008);
    tick(2); chkOut("R9");
    setIn(32'h0008_0000);
    tick(2); chkOut("R9");
    setIn(32'd0); tick(2);

    // R6 R10 target sweep with source 5 held pending
    setIn(32'h20);
    for (int t = 0; t < NCPU; t++) begin
      busWrite(4, 32'hF0 | 32'(t));
      tick(2);
      chkRd(4, 32'(t), "R6");
      chkOut("R10");
    end
    busWrite(4, 32'h13);
    tick(2); chkRd(4, 32'd3, "R6"); chkOut("R10");
    setIn(32'd0); tick(2);

    // R4 discard: disable pending source 9
    setIn(32'h200); tick(2); chkOut("R9");
    busWrite(3, 32'h200); tick(2);
    chkState("R4"); chkOut("R4");
    busWrite(2, 32'h200); tick(2);
    chkRd(0, 32'd0, "R4"); chkOut("R4");
    setIn(32'd0); setIn(32'h200); tick(2);
    chkOut("R3");
    setIn(32'd0); tick(2);

    // R7 masked source still records, delivered once enabled
    busWrite(3, 32'h400);
    setIn(32'h400); tick(2);
    chkRd(0, 32'h400, "R7"); chkOut("R7");
    busWrite(2, 32'h400); tick(2); chkOut("R3");
    setIn(32'd0); tick(2);

    // R4 collision: rising edge and discard on the same edge
    irqIn[12] = 1'b1;
    busWrite(3, 32'h1000);
    tick(2);
    chkRd(0, 32'd0, "R4"); chkOut("R4");
    busWrite(2, 32'h1000); tick(2); chkOut("R4");
    setIn(32'd0); tick(2);

    // R5 fixed bits and R8 gate
    busWrite(3, 32'hFFFF_FFFF); tick(1);
    chkRd(1, 32'hB04D_FF80, "R5");
    setIn(32'h2); tick(2);
    chkRd(0, 32'h2, "R8");
    checks++;
    if (cpuLvlReq !== '0) begin
      errors++;
      $display("FAIL R8 outputs actual=%h expected=0", cpuLvlReq);
    end
    busWrite(2, 32'h8000_0000); tick(2);
    chkRd(1, 32'h304D_FF80, "R5");
    chkOut("R8");
    busWrite(2, 32'hFFFF_FFFF); tick(1);
    chkRd(1, 32'd0, "R5");

    // R11 writes to other offsets are ignored
    setIn(32'h4); tick(1);
    busWrite(0, 32'hFFFF_FFFF);
    busWrite(1, 32'hFFFF_FFFF);
    busWrite(5, 32'hFFFF_FFFF);
    busWrite(6, 32'hFFFF_FFFF);
    busWrite(7, 32'hFFFF_FFFF);
    tick(2);
    chkState("R11"); chkOut("R11");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule